// File: doc/BRIEF.md
# Sleep Entry and Recovery Controller

This block sits in front of a synchronous memory interface and handles its low-power sleep request. The request arrives asynchronously. It is active high, and an undriven request is treated as low. The block first passes the request through a synchronizer. Once the synchronized request has been seen high, the block waits a fixed number of cycles and then declares sleep. While asleep, it blocks every command and forces the data outputs off. The block never touches stored state, so memory contents and other state survive sleep unchanged.

When the request drops, the block opens a recovery window of a parameterised number of clock cycles. The default of three cycles covers 20 ns at 125 MHz. Inside the window, deselect and read commands still go through. Write-class commands are held back, and each one that is held back sets a sticky error flag. Only a reset clears that flag. If the request comes back during recovery, the block returns to the entry delay. If the request drops during the entry delay, the block returns to normal operation without ever sleeping.

The memory control path uses three signals from this block:
- the per-command pass and block signals,
- the output-off flag,
- the state flags.

Top module: `slp_ctrl`

## Requirements
- R1: During and after reset the block is awake: `asleep_o`, `recovering_o`, `out_off_o` and `wr_err_o` are all 0.
- R2: The request passes through two flops, then waits two entry cycles. With the defaults, `asleep_o` rises after the fifth rising edge that follows the first edge at which `sleep_req_i` is high. Until then, commands pass normally.
- R3: While asleep:
  - `cmd_pass_o` is 0 for every command.
  - `cmd_block_o` equals `cmd_valid_i`.
  - `out_off_o` is 1.
  - No command affects `wr_err_o`.
- R4: After the request drops, `asleep_o` falls and `recovering_o` rises after the third edge. `recovering_o` then stays high for REC_CYC cycles (default 3), after which the block is awake.
- R5: During recovery, command class 2'b00 (deselect) and class 2'b01 (read) pass. Classes 2'b10 and 2'b11 (write class, bit 1 set) are blocked.
- R6: A valid write-class command during recovery sets `wr_err_o` at the next edge. The flag then stays set until reset.
- R7: If the request returns high during recovery, the block leaves recovery and re-runs the entry delay, then sleeps again.
- R8: If the request drops during the entry delay, the block returns to awake and does not sleep.
- R9: When awake or in the entry delay, every valid command passes. When `cmd_valid_i` is 0, `cmd_pass_o` and `cmd_block_o` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_req_i | input | 1 | Asynchronous sleep request, active high |
| cmd_valid_i | input | 1 | A command is presented this cycle |
| cmd_class_i | input | 2 | 00 deselect, 01 read, 1x write class |
| cmd_pass_o | output | 1 | Command is forwarded to the memory |
| cmd_block_o | output | 1 | Command is dropped by the controller |
| out_off_o | output | 1 | Forces the data outputs off |
| asleep_o | output | 1 | Sleep is in effect |
| recovering_o | output | 1 | Recovery window is open |
| wr_err_o | output | 1 | Sticky: a write was refused during recovery |

## Verification
The bench counts the exact edge at which sleep begins and the exact edge at which recovery ends. A design with one synchronizer flop too few or too many would move `asleep_o` by one cycle and fail. It also sends a write while asleep and another write in the first recovery cycle. A design that blocked nothing during recovery, or that flagged writes made while asleep, would then show the wrong pass or error value. A short request pulse and a request that returns in mid-recovery cover the two abort paths. A controller lacking either path would sleep when it should not, or stay in recovery.

// File: rtl/slp_pkg.sv
package slp_pkg;

  typedef enum logic [1:0] {
    ST_AWAKE   = 2'd0,
    ST_ENTER   = 2'd1,
    ST_ASLEEP  = 2'd2,
    ST_RECOVER = 2'd3
  } slp_state_e;

  localparam logic [1:0] CLS_DESEL = 2'b00;
  localparam logic [1:0] CLS_READ  = 2'b01;

  // Write class is any code with bit 1 set.
  function automatic logic cls_is_write(input logic [1:0] cls);
    return cls[1];
  endfunction

  // True when a zero-based counter sits on the last cycle of a window of lim cycles.
  function automatic logic cnt_at_last(input logic [31:0] cnt, input logic [31:0] lim);
    return cnt == (lim - 32'd1);
  endfunction

endpackage

// File: rtl/slp_sync.sv
module slp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
  import slp_pkg::*;
#(
  parameter int unsigned ENTRY_CYC = 2,
  parameter int unsigned REC_CYC   = 3,
  parameter int          CW        = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_s,
  output slp_state_e state_o,
  output logic       ent_done_o,
  output logic       rec_done_o
);
  slp_state_e     state, nxt_state;
  logic [CW-1:0]  cnt, nxt_cnt;

  assign ent_done_o = (state == ST_ENTER)   && cnt_at_last(32'(cnt), 32'(ENTRY_CYC));
  assign rec_done_o = (state == ST_RECOVER) && cnt_at_last(32'(cnt), 32'(REC_CYC));
  assign state_o    = state;

  always_comb begin
    nxt_state = state;
    nxt_cnt   = '0;
    unique case (state)
      ST_AWAKE:   if (req_s) nxt_state = ST_ENTER;
      ST_ENTER: begin
        if (!req_s)          nxt_state = ST_AWAKE;
        else if (ent_done_o) nxt_state = ST_ASLEEP;
        else                 nxt_cnt   = cnt + 1'b1;
      end
      ST_ASLEEP:  if (!req_s) nxt_state = ST_RECOVER;
      ST_RECOVER: begin
        if (req_s)           nxt_state = ST_ENTER;
        else if (rec_done_o) nxt_state = ST_AWAKE;
        else                 nxt_cnt   = cnt + 1'b1;
      end
      default:    nxt_state = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_AWAKE;
      cnt   <= '0;
    end else begin
      state <= nxt_state;
      cnt   <= nxt_cnt;
    end
  end

  assert_sleep_only_after_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ASLEEP && $past(state) != ST_ASLEEP) |-> ($past(state) == ST_ENTER && $past(ent_done_o)));

  assert_recovery_ends_on_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_RECOVER && state == ST_AWAKE) |-> ($past(rec_done_o) && !$past(req_s)));

  assert_reentry_from_recovery_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RECOVER && req_s) |=> state == ST_ENTER);

  assert_entry_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ENTER && !req_s) |=> state == ST_AWAKE);
endmodule

// File: rtl/slp_gate.sv
module slp_gate
  import slp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  slp_state_e state_i,
  input  logic       cmd_valid_i,
  input  logic [1:0] cmd_class_i,
  output logic       cmd_pass_o,
  output logic       cmd_block_o,
  output logic       out_off_o,
  output logic       wr_err_o,
  output logic       rec_wr_evt_o
);
  logic open_all, in_rec, err_q;

  assign open_all     = (state_i == ST_AWAKE) || (state_i == ST_ENTER);
  assign in_rec       = (state_i == ST_RECOVER);
  assign cmd_pass_o   = cmd_valid_i && (open_all || (in_rec && !cls_is_write(cmd_class_i)));
  assign cmd_block_o  = cmd_valid_i && !cmd_pass_o;
  assign out_off_o    = (state_i == ST_ASLEEP);
  assign rec_wr_evt_o = in_rec && cmd_valid_i && cls_is_write(cmd_class_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            err_q <= 1'b0;
    else if (rec_wr_evt_o) err_q <= 1'b1;
  end
  assign wr_err_o = err_q;

  assert_sleep_blocks_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_off_o |-> (!cmd_pass_o && (cmd_block_o == cmd_valid_i)));

  assert_rec_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rec_wr_evt_o |-> cmd_block_o);

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err_o |=> wr_err_o);

  assert_err_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_err_o) |-> $past(rec_wr_evt_o));

  assert_pass_block_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_pass_o && cmd_block_o));
endmodule

// File: rtl/slp_ctrl.sv
module slp_ctrl
  import slp_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned ENTRY_CYC   = 2,
  parameter int unsigned REC_CYC     = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req_i,
  input  logic       cmd_valid_i,
  input  logic [1:0] cmd_class_i,
  output logic       cmd_pass_o,
  output logic       cmd_block_o,
  output logic       out_off_o,
  output logic       asleep_o,
  output logic       recovering_o,
  output logic       wr_err_o
);
  localparam int unsigned MAXC = (ENTRY_CYC > REC_CYC) ? ENTRY_CYC : REC_CYC;
  localparam int          CW   = (MAXC < 2) ? 1 : $clog2(MAXC);

  logic       req_s, ent_done, rec_done, rec_wr_evt;
  slp_state_e state;

  slp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(sleep_req_i), .q_o(req_s)
  );

  slp_fsm #(.ENTRY_CYC(ENTRY_CYC), .REC_CYC(REC_CYC), .CW(CW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_s(req_s), .state_o(state),
    .ent_done_o(ent_done), .rec_done_o(rec_done)
  );

  slp_gate u_gate (
    .clk(clk), .rst_n(rst_n), .state_i(state),
    .cmd_valid_i(cmd_valid_i), .cmd_class_i(cmd_class_i),
    .cmd_pass_o(cmd_pass_o), .cmd_block_o(cmd_block_o),
    .out_off_o(out_off_o), .wr_err_o(wr_err_o), .rec_wr_evt_o(rec_wr_evt)
  );

  assign asleep_o     = (state == ST_ASLEEP);
  assign recovering_o = (state == ST_RECOVER);

  assert_flags_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({asleep_o, recovering_o}));

  assert_recovery_follows_sleep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(recovering_o) |-> $past(asleep_o));
endmodule

// File: tb/tb_slp_ctrl.sv
module tb_slp_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sleep_req_i = 1'b0, cmd_valid_i = 1'b0;
  logic [1:0] cmd_class_i = 2'b00;
  logic cmd_pass_o, cmd_block_o, out_off_o, asleep_o, recovering_o, wr_err_o;
  int n_tests = 0, n_fail = 0;

  always #4 clk = ~clk;

  slp_ctrl dut (
    .clk(clk), .rst_n(rst_n), .sleep_req_i(sleep_req_i),
    .cmd_valid_i(cmd_valid_i), .cmd_class_i(cmd_class_i),
    .cmd_pass_o(cmd_pass_o), .cmd_block_o(cmd_block_o), .out_off_o(out_off_o),
    .asleep_o(asleep_o), .recovering_o(recovering_o), .wr_err_o(wr_err_o)
  );

  // Vector: req, valid, class[1:0], then expected pass, block, off, asleep, recovering.
  localparam int NV = 15;
  localparam logic [8:0] VEC [NV] = '{
    9'b0_1_01_10000, 9'b0_1_10_10000, 9'b1_1_01_10000, 9'b1_1_10_10000,
    9'b1_1_10_10000, 9'b1_1_01_10000, 9'b1_1_10_10000, 9'b1_1_01_01110,
    9'b0_1_10_01110, 9'b0_0_00_00110, 9'b0_1_01_01110, 9'b0_1_01_10001,
    9'b0_1_00_10001, 9'b0_0_01_00001, 9'b0_1_10_10000
  };

  function automatic logic [5:0] outs();
    return {cmd_pass_o, cmd_block_o, out_off_o, asleep_o, recovering_o, wr_err_o};
  endfunction

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: pass/block/off/asleep/rec/err actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    #(8 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state, with a write presented.
    cmd_valid_i = 1'b1; cmd_class_i = 2'b10;
    tick(3); #1;
    check("R1 in reset", outs(), 6'b100000);
    rst_n = 1'b1;
    #1;

    // Table walk: R2 entry timing, R3 sleep gating, R4/R5 recovery, R9 awake pass.
    for (int i = 0; i < NV; i++) begin
      sleep_req_i = VEC[i][8]; cmd_valid_i = VEC[i][7]; cmd_class_i = VEC[i][6:5];
      #1;
      check($sformatf("R2/R3/R4/R5/R9 vec %0d", i), outs(), {VEC[i][4:0], 1'b0});
      tick(1);
    end
    cmd_valid_i = 1'b0; sleep_req_i = 1'b0;

    // R5/R6: write refused in recovery, error sets and sticks.
    sleep_req_i = 1'b1; tick(4); #1;
    check("R2 not yet asleep", outs(), 6'b000000);
    tick(1); #1;
    check("R2 asleep on fifth edge", outs(), 6'b001100);
    sleep_req_i = 1'b0; tick(3);
    cmd_valid_i = 1'b1; cmd_class_i = 2'b10; #1;
    check("R5 write blocked in recovery", outs(), 6'b010010);
    tick(1);
    cmd_class_i = 2'b11; #1;
    check("R6 error set, R5 class 11 blocked", outs(), 6'b010011);
    cmd_valid_i = 1'b0; tick(2); #1;
    check("R4/R6 awake, error sticky", outs(), 6'b000001);
    cmd_valid_i = 1'b1; cmd_class_i = 2'b10; #1;
    check("R6 awake write passes, no change", outs(), 6'b100001);
    cmd_valid_i = 1'b0;

    rst_n = 1'b0; #1;
    check("R1 reset clears error", outs(), 6'b000000);
    tick(1); rst_n = 1'b1;

    // R7: request back during recovery.
    sleep_req_i = 1'b1; tick(5); #1;
    check("R7 asleep before test", outs(), 6'b001100);
    sleep_req_i = 1'b0; tick(1);
    sleep_req_i = 1'b1; tick(2); #1;
    check("R7 recovery opened", outs(), 6'b000010);
    tick(1); #1;
    check("R7 back in entry delay", outs(), 6'b000000);
    tick(2); #1;
    check("R7 asleep again", outs(), 6'b001100);
    sleep_req_i = 1'b0; tick(6); #1;
    check("R4 awake after full recovery", outs(), 6'b000000);

    // R8: short pulse aborts entry.
    sleep_req_i = 1'b1; tick(1);
    sleep_req_i = 1'b0; tick(2); #1;
    check("R8 in entry delay", outs(), 6'b000000);
    tick(4);
    cmd_valid_i = 1'b1; cmd_class_i = 2'b10; #1;
    check("R8/R9 never slept, write passes", outs(), 6'b100000);
    cmd_valid_i = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule